// File: doc/BRIEF.md
# Indirect Configuration Table Access Controller

This block lets a host reach two internal configuration tables through a narrow 32-bit register window instead of mapping every table word. One table keeps per-scheme configuration records (23 words each). The other keeps per-port records made of a scheme-binding word and a plan-binding word. The host fills a set of staging registers, then writes an action word that names the table, the entry, the direction and the words concerned. The block raises a busy flag, moves one word per clock between the staging registers and the chosen entry, and drops the flag when done. A request that names a missing entry or a reserved table code is refused: nothing moves, and an error flag tells the host.

Staging word 16 of a scheme record is the record's packet counter. It is committed only when the request asks for it. A scheme transfer always lasts one cycle per record word. A port transfer always lasts two cycles: cycle 0 carries the binding word and cycle 1 the plan word. The host polls the action register until the busy bit reads zero, then reads the error bit.

Top module: `kg_table_access`

## Requirements
- R1: After reset, the action register, the configuration register and every port record read as zero.
- R2: The action word layout is: bit 31 busy/start, bit 30 direction (1 = entry to staging, 0 = staging to entry), bit 29 error, bits 25:24 table code (00 scheme, 10 port, 01 plan word of a port record, 11 reserved), bits 23:16 entry number, bits 15:14 word selects. Writing it with the block idle sets bit 31, which clears by itself when the transfer ends.
- R3: A scheme write followed by a scheme read of the same entry returns all 23 staged words. Entries 0 and 31 are both usable.
- R4: On a scheme write, staging word 16 is committed only when action bit 15 is set. Otherwise the entry keeps its old word 16 while all other words are updated.
- R5: For the port table, bit 15 enables the binding word and bit 14 the plan word. A word that is not enabled is neither written to the table nor loaded into staging.
- R6: Table code 01 moves only the plan word of the addressed port record, whatever bits 15:14 hold.
- R7: The error bit is set and neither the tables nor the staging registers change when the entry number is not below 32 for schemes, not below 64 for ports or plan words, or when the table code is 11.
- R8: A write to the action register while bit 31 is set is ignored.
- R9: A legal request clears an error bit left by an earlier request.
- R10: The word-addressed map: 0 configuration, 1 scheme event, 2 scheme event enable (all plain read/write), 3 action, 8 to 30 scheme staging words 0 to 22, 32 port binding staging, 33 port plan staging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |

## Verification
Scheme records are exchanged with distinct per-word patterns for each entry, which separates a word-offset fault from an entry-decoding fault. A write that omits the counter flag tells the counter guard apart from the general write path. Port requests are tried with only one select bit, with both bits, and through the plan code, which shows that each word enable is decoded on its own. A table of legal and illegal action words alternates good and bad requests, so a sticky or missing error flag shows up. The ignored-request tests then read the staging and entry contents back.

// File: rtl/kg_ixs_pkg.sv
package kg_ixs_pkg;
  typedef enum logic [1:0] {
    TGT_SCHEME = 2'b00,
    TGT_PLAN   = 2'b01,
    TGT_PORT   = 2'b10,
    TGT_RSVD   = 2'b11
  } tgt_e;

  localparam int unsigned BIT_GO   = 31;
  localparam int unsigned BIT_DIR  = 30;
  localparam int unsigned BIT_ERR  = 29;
  localparam int unsigned TGT_LSB  = 24;
  localparam int unsigned IDX_LSB  = 16;
  localparam int unsigned WSEL_LSB = 14;

  // entry number legality for a given table code
  function automatic logic entry_ok(logic [1:0] tgt, logic [7:0] idx,
                                    int unsigned n_sch, int unsigned n_port);
    case (tgt)
      2'b00:        return (32'(idx) < n_sch);
      2'b01, 2'b10: return (32'(idx) < n_port);
      default:      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/kg_action_decode.sv
module kg_action_decode
  import kg_ixs_pkg::*;
#(
  parameter int unsigned NUM_SCHEMES  = 32,
  parameter int unsigned NUM_PORTS    = 64,
  parameter int unsigned SCHEME_WORDS = 23,
  localparam int unsigned CW = $clog2(SCHEME_WORDS)
) (
  input  logic [31:0]   act_word,
  output logic          legal,
  output tgt_e          tgt,
  output logic [7:0]    idx,
  output logic          dir,
  output logic [1:0]    wsel,
  output logic [CW-1:0] last
);
  assign tgt   = tgt_e'(act_word[TGT_LSB +: 2]);
  assign idx   = act_word[IDX_LSB +: 8];
  assign dir   = act_word[BIT_DIR];
  assign wsel  = act_word[WSEL_LSB +: 2];
  assign legal = entry_ok(act_word[TGT_LSB +: 2], act_word[IDX_LSB +: 8],
                          NUM_SCHEMES, NUM_PORTS);
  assign last  = (tgt == TGT_SCHEME) ? CW'(SCHEME_WORDS - 1) : CW'(1);
endmodule

// File: rtl/kg_scheme_store.sv
module kg_scheme_store #(
  parameter int unsigned NUM_SCHEMES  = 32,
  parameter int unsigned SCHEME_WORDS = 23,
  parameter int unsigned CNT_WORD     = 16,
  localparam int unsigned EW = $clog2(NUM_SCHEMES),
  localparam int unsigned CW = $clog2(SCHEME_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          cnt_ok,
  input  logic [EW-1:0] ent,
  input  logic [CW-1:0] word,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem_q [NUM_SCHEMES][SCHEME_WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[ent][word] <= wdata;
  end

  assign rdata = mem_q[ent][word];

  // counter word only written when the request carried the counter flag
  assert_cnt_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && word == CW'(CNT_WORD)) |-> cnt_ok);
endmodule

// File: rtl/kg_port_store.sv
module kg_port_store #(
  parameter int unsigned NUM_PORTS = 64,
  localparam int unsigned PW = $clog2(NUM_PORTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_bind,
  input  logic          we_plan,
  input  logic [PW-1:0] ent,
  input  logic [31:0]   wdata_bind,
  input  logic [31:0]   wdata_plan,
  output logic [31:0]   rdata_bind,
  output logic [31:0]   rdata_plan
);
  logic [31:0] bind_q [NUM_PORTS];
  logic [31:0] plan_q [NUM_PORTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        bind_q[i] <= '0;
        plan_q[i] <= '0;
      end
    end else begin
      if (we_bind) bind_q[ent] <= wdata_bind;
      if (we_plan) plan_q[ent] <= wdata_plan;
    end
  end

  assign rdata_bind = bind_q[ent];
  assign rdata_plan = plan_q[ent];

  // the two words of a port record move in separate cycles
  assert_one_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_bind, we_plan}));
endmodule

// File: rtl/kg_table_access.sv
module kg_table_access
  import kg_ixs_pkg::*;
#(
  parameter int unsigned NUM_SCHEMES  = 32,
  parameter int unsigned NUM_PORTS    = 64,
  parameter int unsigned SCHEME_WORDS = 23,
  parameter int unsigned CNT_WORD     = 16,
  parameter int unsigned ADDR_W       = 6,
  localparam int unsigned CW = $clog2(SCHEME_WORDS),
  localparam int unsigned EW = $clog2(NUM_SCHEMES),
  localparam int unsigned PW = $clog2(NUM_PORTS),
  localparam int unsigned A_CFG  = 0,
  localparam int unsigned A_EVT  = 1,
  localparam int unsigned A_EVEN = 2,
  localparam int unsigned A_ACT  = 3,
  localparam int unsigned A_STG  = 8,
  localparam int unsigned A_BIND = A_STG + SCHEME_WORDS + 1,
  localparam int unsigned A_PLAN = A_BIND + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  // host-visible registers
  logic [31:0] cfg_q, evt_q, even_q;
  logic [31:0] stage_q [SCHEME_WORDS];
  logic [31:0] sbind_q, splan_q;

  // latched request
  logic          go_q, dir_q, err_q;
  tgt_e          tgt_q;
  logic [7:0]    idx_q;
  logic [1:0]    wsel_q;
  logic [CW-1:0] cnt_q, last_q;

  // decode of the incoming action word
  logic          d_legal, d_dir;
  tgt_e          d_tgt;
  logic [7:0]    d_idx;
  logic [1:0]    d_wsel;
  logic [CW-1:0] d_last;

  kg_action_decode #(
    .NUM_SCHEMES (NUM_SCHEMES),
    .NUM_PORTS   (NUM_PORTS),
    .SCHEME_WORDS(SCHEME_WORDS)
  ) u_dec (
    .act_word(reg_wdata),
    .legal   (d_legal),
    .tgt     (d_tgt),
    .idx     (d_idx),
    .dir     (d_dir),
    .wsel    (d_wsel),
    .last    (d_last)
  );

  // named internal events
  logic act_hit, act_start, xfer_en, xfer_done;
  logic sch_we, bind_en, plan_en;
  logic [31:0] sch_rdata, prd_bind, prd_plan;

  assign act_hit   = reg_wr && (reg_addr == ADDR_W'(A_ACT));
  assign act_start = act_hit && !go_q;
  assign xfer_en   = go_q && !err_q;
  assign xfer_done = go_q && (err_q || cnt_q == last_q);
  assign sch_we    = xfer_en && !dir_q && (tgt_q == TGT_SCHEME) &&
                     ((cnt_q != CW'(CNT_WORD)) || wsel_q[1]);
  assign bind_en   = xfer_en && (tgt_q == TGT_PORT) && wsel_q[1] &&
                     (cnt_q == CW'(0));
  assign plan_en   = xfer_en && (cnt_q == CW'(1)) &&
                     (((tgt_q == TGT_PORT) && wsel_q[0]) || (tgt_q == TGT_PLAN));

  kg_scheme_store #(
    .NUM_SCHEMES (NUM_SCHEMES),
    .SCHEME_WORDS(SCHEME_WORDS),
    .CNT_WORD    (CNT_WORD)
  ) u_sch (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sch_we),
    .cnt_ok(wsel_q[1]),
    .ent   (idx_q[EW-1:0]),
    .word  (cnt_q),
    .wdata (stage_q[cnt_q]),
    .rdata (sch_rdata)
  );

  kg_port_store #(.NUM_PORTS(NUM_PORTS)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_bind   (bind_en && !dir_q),
    .we_plan   (plan_en && !dir_q),
    .ent       (idx_q[PW-1:0]),
    .wdata_bind(sbind_q),
    .wdata_plan(splan_q),
    .rdata_bind(prd_bind),
    .rdata_plan(prd_plan)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      evt_q   <= '0;
      even_q  <= '0;
      sbind_q <= '0;
      splan_q <= '0;
      for (int i = 0; i < SCHEME_WORDS; i++) stage_q[i] <= '0;
      go_q    <= 1'b0;
      dir_q   <= 1'b0;
      err_q   <= 1'b0;
      tgt_q   <= TGT_SCHEME;
      idx_q   <= '0;
      wsel_q  <= '0;
      cnt_q   <= '0;
      last_q  <= '0;
    end else begin
      // host register writes
      if (reg_wr) begin
        if (reg_addr == ADDR_W'(A_CFG))  cfg_q   <= reg_wdata;
        if (reg_addr == ADDR_W'(A_EVT))  evt_q   <= reg_wdata;
        if (reg_addr == ADDR_W'(A_EVEN)) even_q  <= reg_wdata;
        if (reg_addr == ADDR_W'(A_BIND)) sbind_q <= reg_wdata;
        if (reg_addr == ADDR_W'(A_PLAN)) splan_q <= reg_wdata;
        for (int i = 0; i < SCHEME_WORDS; i++)
          if (reg_addr == ADDR_W'(A_STG + i)) stage_q[i] <= reg_wdata;
      end
      // request sequencing
      if (act_start) begin
        go_q   <= 1'b1;
        err_q  <= !d_legal;
        dir_q  <= d_dir;
        tgt_q  <= d_tgt;
        idx_q  <= d_idx;
        wsel_q <= d_wsel;
        last_q <= d_last;
        cnt_q  <= '0;
      end else if (go_q) begin
        if (xfer_done) go_q <= 1'b0;
        else           cnt_q <= cnt_q + CW'(1);
      end
      // entry-to-staging loads take priority over host writes
      if (xfer_en && dir_q) begin
        if (tgt_q == TGT_SCHEME) stage_q[cnt_q] <= sch_rdata;
        if (bind_en) sbind_q <= prd_bind;
        if (plan_en) splan_q <= prd_plan;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_CFG))  reg_rdata = cfg_q;
    if (reg_addr == ADDR_W'(A_EVT))  reg_rdata = evt_q;
    if (reg_addr == ADDR_W'(A_EVEN)) reg_rdata = even_q;
    if (reg_addr == ADDR_W'(A_ACT))
      reg_rdata = {go_q, dir_q, err_q, 3'b000, tgt_q, idx_q, wsel_q, 14'd0};
    if (reg_addr == ADDR_W'(A_BIND)) reg_rdata = sbind_q;
    if (reg_addr == ADDR_W'(A_PLAN)) reg_rdata = splan_q;
    for (int i = 0; i < SCHEME_WORDS; i++)
      if (reg_addr == ADDR_W'(A_STG + i)) reg_rdata = stage_q[i];
  end

  // start while busy leaves the latched request alone
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && act_hit) |=> ($stable(idx_q) && $stable(tgt_q) && $stable(dir_q)));

  // illegal request: flagged at once, no transfer cycle follows
  assert_err_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_start && !d_legal) |=> (go_q && err_q));

  assert_err_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && err_q) |=> !go_q);

  // a legal transfer stays busy until its last word
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !err_q && cnt_q != last_q) |=> go_q);

  // a legal start clears a stale error
  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_start && d_legal) |=> !err_q);
endmodule

// File: tb/kg_table_access_tb.sv
module kg_table_access_tb;
  localparam int NW     = 23;
  localparam int A_CFG  = 0;
  localparam int A_EVT  = 1;
  localparam int A_EVEN = 2;
  localparam int A_ACT  = 3;
  localparam int A_STG  = 8;
  localparam int A_BIND = 32;
  localparam int A_PLAN = 33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  kg_table_access u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {action word, expected error}
  localparam logic [32:0] VEC [8] = '{
    {32'hC007_0000, 1'b0},   // read scheme 7
    {32'hC020_0000, 1'b1},   // scheme 32: out of range
    {32'hC01F_0000, 1'b0},   // read scheme 31
    {32'hC240_C000, 1'b1},   // port 64: out of range
    {32'hC23F_C000, 1'b0},   // read port 63
    {32'hC300_0000, 1'b1},   // reserved table code
    {32'hC100_0000, 1'b0},   // plan word of port 0
    {32'hC140_0000, 1'b1}    // plan word of port 64
  };

  function automatic logic [31:0] pat(int ent, int k, logic [7:0] seed);
    return {seed, 8'(ent), 8'(k), 8'h3C};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(a);
    #2 d = reg_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] a);
    a = 32'hFFFF_FFFF;
    for (int i = 0; i < 200; i++) begin
      rd(A_ACT, a);
      if (!a[31]) break;
    end
  endtask

  task automatic fill_scheme(int ent, logic [7:0] seed);
    for (int k = 0; k < NW; k++) wr(A_STG + k, pat(ent, k, seed));
  endtask

  task automatic act(logic [31:0] w, output logic [31:0] a);
    wr(A_ACT, w);
    wait_idle(a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %08h expected %08h", 32'h1, 32'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    rd(A_ACT, d); check("R1 action", d, 32'h0);
    rd(A_CFG, d); check("R1 cfg", d, 32'h0);
    wr(A_BIND, 32'hFFFF_FFFF); wr(A_PLAN, 32'hFFFF_FFFF);
    act(32'hC205_C000, a);
    rd(A_BIND, d); check("R1 port bind", d, 32'h0);
    rd(A_PLAN, d); check("R1 port plan", d, 32'h0);

    // R10: plain registers
    wr(A_CFG, 32'h8000_0000); wr(A_EVT, 32'h1234_0001); wr(A_EVEN, 32'hFFFF_0000);
    rd(A_CFG, d);  check("R10 cfg", d, 32'h8000_0000);
    rd(A_EVT, d);  check("R10 evt", d, 32'h1234_0001);
    rd(A_EVEN, d); check("R10 even", d, 32'hFFFF_0000);

    // R3 / R2: scheme round trip on entries 7 and 31
    fill_scheme(7, 8'h11);
    wr(A_ACT, 32'h8007_8000);
    rd(A_ACT, d); check("R2 busy after start", {31'd0, d[31]}, 32'h1);
    wait_idle(a); check("R2 self-clear", {31'd0, a[31]}, 32'h0);
    fill_scheme(31, 8'h22);
    act(32'h801F_8000, a);
    for (int k = 0; k < NW; k++) wr(A_STG + k, 32'h0);
    act(32'hC007_0000, a);
    for (int k = 0; k < NW; k++) begin
      rd(A_STG + k, d); check("R3 entry 7", d, pat(7, k, 8'h11));
    end
    act(32'hC01F_0000, a);
    for (int k = 0; k < NW; k++) begin
      rd(A_STG + k, d); check("R3 entry 31", d, pat(31, k, 8'h22));
    end

    // R4: write without counter flag keeps word 16
    fill_scheme(7, 8'h33);
    act(32'h8007_0000, a);
    for (int k = 0; k < NW; k++) wr(A_STG + k, 32'h0);
    act(32'hC007_0000, a);
    for (int k = 0; k < NW; k++) begin
      rd(A_STG + k, d);
      check("R4 counter guard", d, pat(7, k, (k == 16) ? 8'h11 : 8'h33));
    end

    // R8: action write while busy is ignored
    wr(A_ACT, 32'hC01F_0000);
    wr(A_ACT, 32'hC007_0000);
    wait_idle(a);
    check("R8 idx kept", {24'd0, a[23:16]}, 32'd31);
    rd(A_STG, d); check("R8 staging from 31", d, pat(31, 0, 8'h22));

    // R7 / R9: vector table of legal and illegal requests
    for (int i = 0; i < 8; i++) begin
      act(VEC[i][32:1], a);
      check(VEC[i][0] ? "R7 error set" : "R9 error clear",
            {31'd0, a[29]}, {31'd0, VEC[i][0]});
      check("R2 fields echoed", {a[30], a[25:14]}, {VEC[i][31], VEC[i][26:15]});
    end

    // R7: illegal write leaves the table, illegal read leaves staging
    fill_scheme(7, 8'h44);
    act(32'h8307_8000, a);
    check("R7 rsvd flagged", {31'd0, a[29]}, 32'h1);
    rd(A_STG + 3, d); check("R7 staging kept", d, pat(7, 3, 8'h44));
    act(32'hC007_0000, a);
    check("R9 cleared", {31'd0, a[29]}, 32'h0);
    rd(A_STG, d); check("R7 table kept", d, pat(7, 0, 8'h33));
    wr(A_STG, 32'h5555_AAAA);
    act(32'hC028_0000, a);
    check("R7 idx 40 flagged", {31'd0, a[29]}, 32'h1);
    rd(A_STG, d); check("R7 no load", d, 32'h5555_AAAA);

    // R5: port word selects
    wr(A_BIND, 32'h1234_5678); wr(A_PLAN, 32'h9ABC_DEF0);
    act(32'h823F_8000, a);
    wr(A_BIND, 32'h0); wr(A_PLAN, 32'h1);
    act(32'hC23F_C000, a);
    rd(A_BIND, d); check("R5 bind written", d, 32'h1234_5678);
    rd(A_PLAN, d); check("R5 plan not written", d, 32'h0);
    wr(A_BIND, 32'hAAAA_AAAA); wr(A_PLAN, 32'hBBBB_BBBB);
    act(32'hC23F_4000, a);
    rd(A_BIND, d); check("R5 bind not loaded", d, 32'hAAAA_AAAA);
    rd(A_PLAN, d); check("R5 plan loaded", d, 32'h0);

    // R6: plan code moves the plan word only
    wr(A_BIND, 32'h0000_DEAD); wr(A_PLAN, 32'hC0FF_EE01);
    act(32'h810A_C000, a);
    wr(A_BIND, 32'h7); wr(A_PLAN, 32'h7);
    act(32'hC20A_C000, a);
    rd(A_BIND, d); check("R6 bind untouched", d, 32'h0);
    rd(A_PLAN, d); check("R6 plan written", d, 32'hC0FF_EE01);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule